// File: doc/BRIEF.md
# Bus-Mapped I/O Expansion Register Bank

This block is a small register bank placed on the asynchronous external bus of a processor. It gives the processor control over a few board-level signals that the processor has no pins for. One active-low chip select and two address bits pick one of four byte-wide registers. The processor reads and writes only the low byte of the 32-bit data bus. Its upper 24 bits read back as ones, as they would from a bus with pull-ups.

The control register drives the following:
- the direction and value of two general-purpose pins,
- the clear-to-send line of a UART in data-communications-equipment role,
- the select between two preset clock configurations,
- a reset for the USB transceiver and a reset for the expansion connector.

Reading the same address returns different content. It gives the live pin states, the request-to-send input and the three-bit boot mode set by jumpers.

A second register holds one enable per SPI slave-select line. The buffered MISO line back to the SPI master is driven only while an enabled slave select is asserted.

A third address passes bytes to and from a FIFO-style USB transceiver. Each access produces exactly one single-cycle strobe. The fourth address is a read-only status view of the boot mode and the transceiver's flags. A build without the transceiver reads 0xFF at the data address and never strobes.

Top module: `ioexp_regbank`

## Requirements
- R1: A register access happens only while `csN` is 0. Its register is chosen by `addr`: 0 control, 1 slave-select enables, 2 USB data, 3 status. Strobes seen while `csN` is 1 change no register and produce no USB strobe.
- R2: Bits 31..8 of `rdData` always read as ones. Bits 31..8 of written data have no effect. While no read is in progress, `rdData` is all ones.
- R3: A write to register 0 sets the following outputs: `gpOe[1]` from bit 7 and `gpOe[0]` from bit 6; `gpOut[1]` from bit 5 and `gpOut[0]` from bit 4; `ctsOut` from bit 3; `clkSel` from bit 2; `usbRst` from bit 1; `ioRst` from bit 0.
- R4: A read of register 0 returns the following: bit 7 and bit 6 are the stored directions of GP1 and GP0; bit 5 and bit 4 are the `gpIn[1]` and `gpIn[0]` pin states; bit 3 is `rtsIn`; bits 2..0 are the mode.
- R5: The mode equals `modePins`. A fitted jumper pulls its pin to 0, so a board with no jumpers fitted reads mode 7.
- R6: Register 1 stores written bits 5..0 as the enables for `ssN[5:0]`. Reads return them in bits 5..0, with bits 7..6 as 0.
- R7: `misoEn` is 1 exactly when some `ssN[i]` is 0 while its enable is 1. `misoOut` equals `misoIn` when `misoEn` is 1 and is 0 otherwise.
- R8: Each write to register 2 raises `usbWrStb` for exactly one cycle, whatever the strobe length, with the written byte on `usbWrData`. Each read of register 2 raises `usbRdStb` for exactly one cycle and returns `usbDataIn`.
- R9: A read of register 3 returns the following: bit 7 is 1; bits 6..4 are the mode; bit 3 is 0; bit 2 is `usbNotEnum`; bit 1 is `usbTxFull`; bit 0 is `usbRxEmpty`.
- R10: A write to register 3 changes no output and no stored bit.
- R11: After reset, every writable bit is 0. GP pins are inputs, clock set 0 is selected, both resets are low and all MISO enables are off.
- R12: Read data is registered. `rdData` shows the register one clock after the clock edge that first samples the read strobe, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| addr | input | 2 | Register address |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| wrData | input | 32 | Write data from the processor |
| rdData | output | 32 | Registered read data to the processor |
| modePins | input | 3 | Boot-mode jumper inputs, 0 when fitted |
| gpIn | input | 2 | General-purpose pin states |
| gpOut | output | 2 | General-purpose pin output values |
| gpOe | output | 2 | General-purpose pin output enables |
| rtsIn | input | 1 | UART request-to-send input |
| ctsOut | output | 1 | UART clear-to-send output |
| clkSel | output | 1 | Clock configuration select |
| usbRst | output | 1 | USB transceiver reset |
| ioRst | output | 1 | Expansion connector reset |
| ssN | input | 6 | SPI slave-select lines from the master, active low |
| misoIn | input | 1 | Shared MISO from the slave devices |
| misoOut | output | 1 | Buffered MISO toward the master |
| misoEn | output | 1 | Drive enable for the buffered MISO |
| usbDataIn | input | 8 | Byte presented by the USB receive FIFO |
| usbWrData | output | 8 | Byte toward the USB transmit FIFO |
| usbRdStb | output | 1 | One-cycle receive FIFO pop strobe |
| usbWrStb | output | 1 | One-cycle transmit FIFO push strobe |
| usbRxEmpty | input | 1 | Receive FIFO empty flag |
| usbTxFull | input | 1 | Transmit FIFO full flag |
| usbNotEnum | input | 1 | Transceiver not-enumerated flag |

## Verification
The assertions assume the processor bus is synchronous to `clk`. They also assume `addr` and `csN` stay steady for as long as a read or write strobe is low, and that read and write strobes are never low together. Every bus action in the stimulus follows that pattern: it drives all bus pins together on a falling clock edge, holds them for whole cycles and then releases both strobes and the chip select at once. Jumper, pin and flag inputs change only between bus accesses. A register sampled during a read therefore always shows settled values.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
  localparam int REG_CNT = 4;
  localparam int ADDR_W = 2;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_SSEN = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_USB  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd3;

  typedef struct packed {
    logic [REG_CNT-1:0] wrEn;
    logic               rdEn;
    logic [ADDR_W-1:0]  rdSel;
    logic               usbRdPulse;
    logic               usbWrPulse;
  } busStrobes_t;
endpackage

// File: rtl/ioexp_ctrl.sv
module ioexp_ctrl
  import ioexp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdN,
  input  logic              wrN,
  output busStrobes_t       strb
);
  logic rdAct, wrAct, rdActQ, wrActQ, rdStart, wrStart;

  assign rdAct = ~csN & ~rdN;
  assign wrAct = ~csN & ~wrN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdActQ <= 1'b0;
      wrActQ <= 1'b0;
    end else begin
      rdActQ <= rdAct;
      wrActQ <= wrAct;
    end
  end

  assign rdStart = rdAct & ~rdActQ;
  assign wrStart = wrAct & ~wrActQ;

  always_comb begin
    strb = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      strb.wrEn[i] = wrStart && (addr == ADDR_W'(i));
    end
    strb.rdEn       = rdAct;
    strb.rdSel      = addr;
    strb.usbRdPulse = rdStart && (addr == ADR_USB);
    strb.usbWrPulse = wrStart && (addr == ADR_USB);
  end
endmodule

// File: rtl/ioexp_dpath.sv
module ioexp_dpath
  import ioexp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SS  = 6,
  parameter bit HAS_USB = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [DATA_W-1:0] rdData,
  input  logic [2:0]        modePins,
  input  logic [1:0]        gpIn,
  output logic [1:0]        gpOut,
  output logic [1:0]        gpOe,
  input  logic              rtsIn,
  output logic              ctsOut,
  output logic              clkSel,
  output logic              usbRst,
  output logic              ioRst,
  input  logic [NUM_SS-1:0] ssN,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoEn,
  input  logic [BYTE_W-1:0] usbDataIn,
  output logic [BYTE_W-1:0] usbWrData,
  output logic              usbRdStb,
  output logic              usbWrStb,
  input  logic              usbRxEmpty,
  input  logic              usbTxFull,
  input  logic              usbNotEnum
);
  localparam int PAD_W  = DATA_W - BYTE_W;
  localparam int SS_GAP = BYTE_W - NUM_SS;

  logic [BYTE_W-1:0] ctrlReg;
  logic [NUM_SS-1:0] ssEnReg;
  logic [BYTE_W-1:0] rdByte;
  logic [BYTE_W-1:0] ctrlView, ssenView, usbView, statView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      ssEnReg <= '0;
    end else begin
      if (strb.wrEn[ADR_CTRL]) ctrlReg <= wrByte;
      if (strb.wrEn[ADR_SSEN]) ssEnReg <= wrByte[NUM_SS-1:0];
    end
  end

  assign gpOe   = ctrlReg[7:6];
  assign gpOut  = ctrlReg[5:4];
  assign ctsOut = ctrlReg[3];
  assign clkSel = ctrlReg[2];
  assign usbRst = ctrlReg[1];
  assign ioRst  = ctrlReg[0];

  assign misoEn  = |(ssEnReg & ~ssN);
  assign misoOut = misoEn & misoIn;

  generate
    if (HAS_USB) begin : g_usb
      always_ff @(posedge clk) begin
        if (!rstN) begin
          usbRdStb  <= 1'b0;
          usbWrStb  <= 1'b0;
          usbWrData <= '0;
        end else begin
          usbRdStb <= strb.usbRdPulse;
          usbWrStb <= strb.usbWrPulse;
          if (strb.usbWrPulse) usbWrData <= wrByte;
        end
      end
      assign usbView = usbDataIn;
    end else begin : g_nousb
      assign usbRdStb  = 1'b0;
      assign usbWrStb  = 1'b0;
      assign usbWrData = '0;
      assign usbView   = '1;
    end
  endgenerate

  assign ctrlView = {ctrlReg[7:6], gpIn, rtsIn, modePins};
  assign statView = {1'b1, modePins, 1'b0, usbNotEnum, usbTxFull, usbRxEmpty};

  generate
    if (SS_GAP > 0) begin : g_sspad
      assign ssenView = {{SS_GAP{1'b0}}, ssEnReg};
    end else begin : g_ssfull
      assign ssenView = ssEnReg;
    end
  endgenerate

  always_comb begin
    unique case (strb.rdSel)
      ADR_CTRL: rdByte = ctrlView;
      ADR_SSEN: rdByte = ssenView;
      ADR_USB:  rdByte = usbView;
      default:  rdByte = statView;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '1;
    else if (strb.rdEn) rdData <= {{PAD_W{1'b1}}, rdByte};
    else rdData <= '1;
  end
endmodule

// File: rtl/ioexp_regbank.sv
module ioexp_regbank
  import ioexp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SS  = 6,
  parameter bit HAS_USB = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [1:0]        addr,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [2:0]        modePins,
  input  logic [1:0]        gpIn,
  output logic [1:0]        gpOut,
  output logic [1:0]        gpOe,
  input  logic              rtsIn,
  output logic              ctsOut,
  output logic              clkSel,
  output logic              usbRst,
  output logic              ioRst,
  input  logic [NUM_SS-1:0] ssN,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoEn,
  input  logic [7:0]        usbDataIn,
  output logic [7:0]        usbWrData,
  output logic              usbRdStb,
  output logic              usbWrStb,
  input  logic              usbRxEmpty,
  input  logic              usbTxFull,
  input  logic              usbNotEnum
);
  busStrobes_t strb;

  ioexp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .addr(addr),
    .rdN(rdN), .wrN(wrN), .strb(strb)
  );

  ioexp_dpath #(.DATA_W(DATA_W), .NUM_SS(NUM_SS), .HAS_USB(HAS_USB)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrData[BYTE_W-1:0]),
    .rdData(rdData), .modePins(modePins), .gpIn(gpIn), .gpOut(gpOut),
    .gpOe(gpOe), .rtsIn(rtsIn), .ctsOut(ctsOut), .clkSel(clkSel),
    .usbRst(usbRst), .ioRst(ioRst), .ssN(ssN), .misoIn(misoIn),
    .misoOut(misoOut), .misoEn(misoEn), .usbDataIn(usbDataIn),
    .usbWrData(usbWrData), .usbRdStb(usbRdStb), .usbWrStb(usbWrStb),
    .usbRxEmpty(usbRxEmpty), .usbTxFull(usbTxFull), .usbNotEnum(usbNotEnum)
  );
endmodule

// File: rtl/ioexp_regbank_chk.sv
module ioexp_regbank_chk #(
  parameter int DATA_W = 32,
  parameter int NUM_SS = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic [1:0]        addr,
  input logic              rdN,
  input logic              wrN,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [1:0]        gpOe,
  input logic [1:0]        gpOut,
  input logic              ctsOut,
  input logic              clkSel,
  input logic              usbRst,
  input logic              ioRst,
  input logic [NUM_SS-1:0] ssN,
  input logic              misoIn,
  input logic              misoOut,
  input logic              misoEn,
  input logic              usbRdStb,
  input logic              usbWrStb
);
  logic wrAny;
  assign wrAny = ^wrData;

  // R2: upper bytes of the read bus are always ones
  a_r2_upper_ones: assert property (@(posedge clk) disable iff (!rstN)
    &rdData[DATA_W-1:8]);

  // R7: with no slave select low, the buffered MISO is not driven
  a_r7_miso_idle: assert property (@(posedge clk) disable iff (!rstN)
    (&ssN) |-> (!misoEn && !misoOut));

  // R7: MISO output never shows a 1 the devices did not drive
  a_r7_miso_follow: assert property (@(posedge clk) disable iff (!rstN)
    misoOut |-> misoIn);

  // R8: each USB strobe lasts a single cycle
  a_r8_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    usbWrStb |=> !usbWrStb);

  a_r8_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    usbRdStb |=> !usbRdStb);

  a_r8_not_both: assert property (@(posedge clk) disable iff (!rstN)
    !(usbRdStb && usbWrStb));

  // R1: with chip select high no USB strobe follows
  a_r1_no_cs_no_stb: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !$isunknown(wrAny)) |=> (!usbWrStb && !usbRdStb));

  // R9: constant bits of the status view
  a_r9_stat_const: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rdN && addr == 2'd3) |=> (rdData[7] && !rdData[3]));

  // R10: writes to the status address leave the control outputs untouched
  a_r10_ro_stat: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !wrN && addr == 2'd3) |=>
      ($stable(gpOe) && $stable(gpOut) && $stable(ctsOut) &&
       $stable(clkSel) && $stable(usbRst) && $stable(ioRst)));
endmodule

bind ioexp_regbank ioexp_regbank_chk #(.DATA_W(DATA_W), .NUM_SS(NUM_SS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .addr(addr), .rdN(rdN), .wrN(wrN),
  .wrData(wrData), .rdData(rdData), .gpOe(gpOe), .gpOut(gpOut),
  .ctsOut(ctsOut), .clkSel(clkSel), .usbRst(usbRst), .ioRst(ioRst),
  .ssN(ssN), .misoIn(misoIn), .misoOut(misoOut), .misoEn(misoEn),
  .usbRdStb(usbRdStb), .usbWrStb(usbWrStb)
);

// File: tb/ioexp_regbank_bench.sv
module ioexp_regbank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0] modePins = 3'b111;
  logic [1:0] gpIn = '0, gpOut, gpOe;
  logic rtsIn = 1'b0, ctsOut, clkSel, usbRst, ioRst;
  logic [5:0] ssN = '1;
  logic misoIn = 1'b0, misoOut, misoEn;
  logic [7:0] usbDataIn = '0, usbWrData;
  logic usbRdStb, usbWrStb;
  logic usbRxEmpty = 1'b1, usbTxFull = 1'b0, usbNotEnum = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ioexp_regbank u_ioexp_regbank (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d, input int hold);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; addr = a; wrData = d;
    repeat (hold) @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addr = a;
    @(negedge clk);
    d = rdData;
    csN = 1'b1; rdN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rv;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    ssN = '0; misoIn = 1'b1; #1;
    check("R11 ctrl outputs", {24'd0, gpOe, gpOut, ctsOut, clkSel, usbRst, ioRst}, 32'd0);
    check("R11 miso disabled", {30'd0, misoEn, misoOut}, 32'd0);
    check("R2 idle rdData", rdData, 32'hFFFF_FFFF);
    ssN = '1;

    // R3 and R4: sweep every control byte
    for (int v = 0; v < 256; v++) begin
      busWrite(2'd0, {24'hA5C3E1, 8'(v)}, 1);
      check("R3 ctrl outputs", {24'd0, gpOe, gpOut, ctsOut, clkSel, usbRst, ioRst}, 32'(v));
      gpIn = 2'(v >> 3); rtsIn = v[1];
      busRead(2'd0, rv);
      check("R4 ctrl readback", rv,
            {24'hFFFFFF, 2'(v >> 6), 2'(v >> 3), v[1], 3'b111});
    end

    // R5 and R9: mode and flag sweep
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 8; f++) begin
        modePins = 3'(m);
        {usbNotEnum, usbTxFull, usbRxEmpty} = 3'(f);
        busRead(2'd3, rv);
        check("R9 status view", rv, {24'hFFFFFF, 1'b1, 3'(m), 1'b0, 3'(f)});
      end
      busRead(2'd0, rv);
      check("R5 mode in ctrl", {29'd0, rv[2:0]}, 32'(m));
    end
    modePins = 3'b111;

    // R6 and R7: every enable mask against every select pattern
    for (int e = 0; e < 64; e++) begin
      busWrite(2'd1, {24'hFFFFFF, 2'b11, 6'(e)}, 1);
      busRead(2'd1, rv);
      check("R6 ssen readback", rv, {24'hFFFFFF, 2'b00, 6'(e)});
      for (int s = 0; s < 64; s++) begin
        ssN = 6'(s);
        misoIn = s[0] ^ e[1];
        #1;
        check("R7 miso gate", {30'd0, misoEn, misoOut},
              {30'd0, ((e & ~s & 63) != 0), ((e & ~s & 63) != 0) && (s[0] ^ e[1])});
      end
      ssN = '1;
    end

    // R10: write to status leaves everything
    busWrite(2'd0, 32'h0000_005A, 1);
    busWrite(2'd3, 32'hFFFF_FFA5, 2);
    check("R10 ctrl unchanged", {24'd0, gpOe, gpOut, ctsOut, clkSel, usbRst, ioRst}, 32'h5A);
    busRead(2'd1, rv);
    check("R10 ssen unchanged", rv, {24'hFFFFFF, 2'b00, 6'd63});

    // R1: strobes without chip select do nothing
    @(negedge clk);
    csN = 1'b1; wrN = 1'b0; addr = 2'd0; wrData = 32'h0000_00FF;
    cnt = 0;
    repeat (3) begin @(negedge clk); cnt += usbWrStb; end
    wrN = 1'b1; addr = 2'd2;
    @(negedge clk); wrN = 1'b0;
    repeat (3) begin @(negedge clk); cnt += usbWrStb; end
    wrN = 1'b1; rdN = 1'b0;
    repeat (3) begin @(negedge clk); cnt += usbRdStb; end
    check("R1 no-cs rdData idle", rdData, 32'hFFFF_FFFF);
    rdN = 1'b1;
    @(negedge clk);
    check("R1 no-cs ctrl unchanged", {24'd0, gpOe, gpOut, ctsOut, clkSel, usbRst, ioRst}, 32'h5A);
    check("R1 no-cs strobes", 32'(cnt), 32'd0);

    // R8: write strobes for several hold lengths
    for (int h = 1; h <= 4; h++) begin
      @(negedge clk);
      csN = 1'b0; wrN = 1'b0; addr = 2'd2; wrData = {24'h123456, 8'(8'h30 + h)};
      cnt = 0;
      repeat (h) begin @(negedge clk); cnt += usbWrStb; end
      csN = 1'b1; wrN = 1'b1;
      repeat (2) begin @(negedge clk); cnt += usbWrStb; end
      check("R8 write strobe count", 32'(cnt), 32'd1);
      check("R8 write byte", {24'd0, usbWrData}, 32'(8'h30 + h));
    end

    // R8 and R12: read strobes and registered read data
    for (int h = 1; h <= 4; h++) begin
      usbDataIn = 8'(8'hC0 + 16 * h + h);
      @(negedge clk);
      csN = 1'b0; rdN = 1'b0; addr = 2'd2;
      #1;
      check("R12 not yet registered", rdData, 32'hFFFF_FFFF);
      cnt = 0;
      repeat (h) begin @(negedge clk); cnt += usbRdStb; end
      check("R8 read byte", rdData, {24'hFFFFFF, usbDataIn});
      csN = 1'b1; rdN = 1'b1;
      repeat (2) begin @(negedge clk); cnt += usbRdStb; end
      check("R8 read strobe count", 32'(cnt), 32'd1);
      check("R2 idle after read", rdData, 32'hFFFF_FFFF);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule